// File: doc/BRIEF.md
# Cascadable Serial Command Frame Port

This block is the serial front end of a multi-channel dimming controller. A host shifts a frame into `sdi`, most significant bit first, on the block clock with `shift_en` high. Each frame holds one command byte and then one 12-bit field per channel, the highest-numbered channel first. While the frame moves in, a status frame captured at the previous load moves out on `sdo`. This lets devices form a chain, with each device's `sdo` feeding the next device's `sdi`. After the host has shifted the whole chain, it asserts `load` for one cycle. Every device then decodes what sits in its own shift register.

The upper nibble of the command selects the action. The actions are a grayscale update with correction, a grayscale update in direct mode (correction bypassed), a correction-register write, and a self-test start. The PWM datapath and the fault sensing are outside this block. Open-load flags and the phase-shift state arrive as inputs and are captured into the status frame at each load. A load after a bit count that does not match whole frames is rejected and reported as a sync error.

Top module: `frame_link`

## Requirements
- R1: A frame is FL = 8 + NCH*DW bits (584 by default). A load is accepted only when the number of shifts since the previous load is a nonzero multiple of FL. The command is then the top 8 bits of the shift register, and channel k's field is bits [k*DW +: DW].
- R2: An accepted load whose command upper nibble is 0x0 copies every channel field into `gray_flat`, clears `direct_mode` and clears `selftest_on`.
- R3: An accepted load whose upper nibble is 0x7 does the same grayscale copy, sets `direct_mode` and clears `selftest_on`. The lower nibble has no effect.
- R4: An accepted load whose upper nibble is 0x2 writes the low 6 bits of each channel field into that channel's slot of `cor_flat` and clears `selftest_on`. `gray_flat` and `direct_mode` are left unchanged.
- R5: An accepted load whose upper nibble is 0x5 sets `selftest_on` and changes no other register. Any other nibble changes none of `gray_flat`, `cor_flat`, `direct_mode` or `selftest_on`.
- R6: A load that is not accepted discards the frame and sets `sync_err`. Any accepted load clears `sync_err`. None of these outputs change except on a load cycle.
- R7: On every load the shift register is loaded with the status frame built from the post-load state. Its top byte is {selftest_on, sync_err, phase_in, direct_mode, 4'b0}. Channel k's field is {open_flt[k], 5'b0, cor[k]}. `sdo` presents bit FL-1 right away, and each shift then moves the next lower bit onto `sdo`.
- R8: In chained use, a bit entering on `sdi` appears on `sdo` after exactly FL shifts.
- R9: `open_flt` and `phase_in` are sampled at the load edge. Between loads, changes on them do not reach the status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | Shift one bit this cycle |
| load | input | 1 | Latch and decode the received frame (takes priority over shift) |
| open_flt | input | NCH | Per-channel open-load fault flags |
| phase_in | input | 1 | Phase-shift status to report |
| sdo | output | 1 | Serial data out to the next device |
| gray_flat | output | NCH*DW | Grayscale values, channel k at [k*DW +: DW] |
| cor_flat | output | NCH*6 | Correction values, channel k at [k*6 +: 6] |
| direct_mode | output | 1 | Correction multiply bypassed |
| selftest_on | output | 1 | Self test requested |
| sync_err | output | 1 | Last load was out of frame alignment |

## Verification
The bench aims at the frame-count boundary. It loads after zero bits, after one bit short of a frame and after one bit over. A design with an off-by-one bit counter would accept these bad frames, or reject a good one and raise `sync_err` wrongly. Double-length shifts check that the first frame comes out of `sdo` bit for bit. If the status were reloaded at frame boundaries, this pass-through would break. Correction writes with random data catch a decoder that also touches grayscale. The bench also checks that an unknown command leaves the self-test flag set.

// File: rtl/frame_link.sv
module frame_link #(
  parameter int NCH   = 48,
  parameter int DW    = 12,
  parameter int CMD_W = 8,
  parameter int COR_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdi,
  input  logic                   shift_en,
  input  logic                   load,
  input  logic [NCH-1:0]         open_flt,
  input  logic                   phase_in,
  output logic                   sdo,
  output logic [NCH*DW-1:0]      gray_flat,
  output logic [NCH*COR_W-1:0]   cor_flat,
  output logic                   direct_mode,
  output logic                   selftest_on,
  output logic                   sync_err
);
  localparam int FL    = CMD_W + NCH*DW;
  localparam int CNT_W = $clog2(FL);

  logic [FL-1:0]          sr, stat_nx;
  logic [CNT_W-1:0]       cnt;
  logic                   full;
  logic [NCH*COR_W-1:0]   cor_nx;

  wire [3:0] op      = sr[FL-1 -: 4];
  wire       good    = full && (cnt == '0);
  wire       do_gray = good && (op == 4'h0 || op == 4'h7);
  wire       do_cor  = good && (op == 4'h2);
  wire       do_st   = good && (op == 4'h5);
  wire       dir_nx  = do_gray ? (op == 4'h7) : direct_mode;
  wire       st_nx   = do_st ? 1'b1 : ((do_gray || do_cor) ? 1'b0 : selftest_on);

  assign sdo = sr[FL-1];

  always_comb begin
    stat_nx = '0;
    stat_nx[FL-1 -: CMD_W] = {st_nx, !good, phase_in, dir_nx, {(CMD_W-4){1'b0}}};
    for (int k = 0; k < NCH; k++) begin
      cor_nx[k*COR_W +: COR_W] = do_cor ? sr[k*DW +: COR_W] : cor_flat[k*COR_W +: COR_W];
      stat_nx[k*DW +: DW] = {open_flt[k], {(DW-COR_W-1){1'b0}}, cor_nx[k*COR_W +: COR_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr          <= '0;
      cnt         <= '0;
      full        <= 1'b0;
      gray_flat   <= '0;
      cor_flat    <= '0;
      direct_mode <= 1'b0;
      selftest_on <= 1'b0;
      sync_err    <= 1'b0;
    end else if (load) begin
      sr          <= stat_nx;
      cnt         <= '0;
      full        <= 1'b0;
      cor_flat    <= cor_nx;
      direct_mode <= dir_nx;
      selftest_on <= st_nx;
      sync_err    <= !good;
      if (do_gray) gray_flat <= sr[NCH*DW-1:0];
    end else if (shift_en) begin
      sr <= {sr[FL-2:0], sdi};
      if (cnt == CNT_W'(FL-1)) begin
        cnt  <= '0;
        full <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_link_chk.sv
module frame_link_chk #(
  parameter int GW = 576,
  parameter int CWD = 288
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_en,
  input logic          load,
  input logic          sdo,
  input logic [GW-1:0] gray_flat,
  input logic [CWD-1:0] cor_flat,
  input logic          direct_mode,
  input logic          selftest_on,
  input logic          sync_err
);
  AST_SDO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load) |=> $stable(sdo)); // R7
  AST_GRAY_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(gray_flat)); // R2
  AST_DIRECT_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(direct_mode)); // R3
  AST_COR_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cor_flat)); // R4
  AST_SELFTEST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(selftest_on)); // R5
  AST_SYNC_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sync_err)); // R6
  AST_SYNC_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (load ##1 sync_err) |-> ($stable(gray_flat) && $stable(cor_flat))); // R6
endmodule

bind frame_link frame_link_chk #(.GW(NCH*DW), .CWD(NCH*COR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load), .sdo(sdo),
  .gray_flat(gray_flat), .cor_flat(cor_flat), .direct_mode(direct_mode),
  .selftest_on(selftest_on), .sync_err(sync_err));

// File: tb/frame_link_tb.sv
module frame_link_tb_top;
  localparam int NCH = 48, DW = 12, CW = 8, CORW = 6;
  localparam int FL = CW + NCH*DW;

  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b0, shift_en = 1'b0, load = 1'b0, phase_in = 1'b0;
  logic [NCH-1:0] open_flt = '0;
  logic sdo, direct_mode, selftest_on, sync_err;
  logic [NCH*DW-1:0] gray_flat;
  logic [NCH*CORW-1:0] cor_flat;

  frame_link dut_i (.clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en), .load(load),
    .open_flt(open_flt), .phase_in(phase_in), .sdo(sdo), .gray_flat(gray_flat),
    .cor_flat(cor_flat), .direct_mode(direct_mode), .selftest_on(selftest_on), .sync_err(sync_err));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [NCH*DW-1:0] m_gray = '0;
  logic [NCH*CORW-1:0] m_cor = '0;
  logic m_dir = 1'b0, m_st = 1'b0, m_err = 1'b0;
  logic [FL-1:0] m_stat = '0;

  task automatic check(input string req, input logic [FL-1:0] act, input logic [FL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [FL-1:0] build_status();
    logic [FL-1:0] s = '0;
    s[FL-1 -: CW] = {m_st, m_err, phase_in, m_dir, 4'b0};
    for (int k = 0; k < NCH; k++) s[k*DW +: DW] = {open_flt[k], 5'b0, m_cor[k*CORW +: CORW]};
    return s;
  endfunction

  function automatic logic [FL-1:0] mk_frame(input logic [7:0] cmd);
    logic [FL-1:0] f;
    for (int k = 0; k < NCH; k++) f[k*DW +: DW] = DW'($urandom);
    f[FL-1 -: CW] = cmd;
    return f;
  endfunction

  task automatic model_load(input logic [FL-1:0] fr, input bit ok);
    logic [3:0] op = fr[FL-1 -: 4];
    if (!ok) m_err = 1'b1;
    else begin
      m_err = 1'b0;
      case (op)
        4'h0, 4'h7: begin m_gray = fr[NCH*DW-1:0]; m_dir = (op == 4'h7); m_st = 1'b0; end
        4'h2: begin
          for (int k = 0; k < NCH; k++) m_cor[k*CORW +: CORW] = fr[k*DW +: CORW];
          m_st = 1'b0;
        end
        4'h5: m_st = 1'b1;
        default: ;
      endcase
    end
    m_stat = build_status();
  endtask

  task automatic shift_bits(input logic [FL-1:0] f, input int n, output logic [FL-1:0] cap);
    cap = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdi = f[(FL-1-(i % FL))];
      shift_en = 1'b1;
      if (i < FL) cap[FL-1-i] = sdo;
      @(posedge clk);
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic run(input logic [7:0] cmd, input int n, input bit two);
    logic [FL-1:0] f1, f2, c1, c2;
    bit ok;
    f1 = mk_frame(cmd);
    if (two) begin
      f2 = mk_frame(cmd);
      shift_bits(f2, FL, c1);
      check("R7 status out", c1, m_stat);
      shift_bits(f1, FL, c2);
      check("R8 chain pass", c2, f2);
      ok = 1'b1;
    end else begin
      shift_bits(f1, n, c1);
      if (n == FL) check("R7 status out", c1, m_stat);
      ok = (n != 0) && (n % FL == 0);
      if (n > FL) f1 = '0;
    end
    open_flt = {$urandom, $urandom};
    phase_in = 1'($urandom);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    model_load(f1, ok);
    check("R1 R6 sync_err", FL'(sync_err), FL'(m_err));
    check("R2 gray", FL'(gray_flat), FL'(m_gray));
    check("R4 cor", FL'(cor_flat), FL'(m_cor));
    check("R3 direct", FL'(direct_mode), FL'(m_dir));
    check("R5 selftest", FL'(selftest_on), FL'(m_st));
    check("R7 sdo msb", FL'(sdo), FL'(m_stat[FL-1]));
    open_flt = ~open_flt;
    phase_in = ~phase_in;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [3:0] ops [6];
    seed = $urandom(32'd1357);
    ops = '{4'h0, 4'h7, 4'h2, 4'h5, 4'h3, 4'hF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 R6 reset", FL'({gray_flat, sync_err, direct_mode, selftest_on, sdo}), '0);
    check("R4 reset cor", FL'(cor_flat), '0);
    rst_n = 1'b1;
    run(8'h00, 0, 1'b0);        // R6 zero bits
    run(8'h03, FL, 1'b0);       // R2
    run(8'h7A, FL, 1'b0);       // R3
    run(8'h2F, FL, 1'b0);       // R4
    run(8'h55, FL, 1'b0);       // R5
    run(8'h3C, FL, 1'b0);       // R5 unknown keeps self test
    run(8'h01, FL-1, 1'b0);     // R6 one short
    run(8'h01, FL+1, 1'b0);     // R6 one over
    run(8'h01, FL, 1'b0);       // R9 fresh capture
    run(8'h72, FL, 1'b1);       // R8
    for (int it = 0; it < 26; it++) begin
      int pick = int'($urandom % 6);
      logic [7:0] cmd = {ops[$urandom % 6], 4'($urandom)};
      if (pick == 0) run(cmd, 1 + int'($urandom % (FL + 40)), 1'b0);
      else if (pick == 1) run(cmd, FL, 1'b1);
      else run(cmd, FL, 1'b0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule